// File: doc/BRIEF.md
# Inter-Core Data Marshal Buffer

This block sits next to a core's private cache and keeps a short list of the cache blocks that the current code segment produced for the next one. Each committed store arrives with its byte address and a flag that the compiler sets on generator stores, the last write to a block that the following segment will read. Only flagged stores enter the list. Entries are kept at cache-block granularity, and no block appears twice among the entries still waiting to be sent.

When the core reaches its marshal instruction, a command carrying the destination core number is presented. The block takes the command and then emits one push request per recorded block, oldest first, over a valid/ready handshake. The cache uses these requests to copy each block into the destination core's cache before that core starts the next segment. Marshaling only speeds things up, so a full list drops new addresses and correctness does not depend on them. Once the last pending entry is accepted, the list is empty and a new command can be taken.

Top module: `mb_marshal_buf`

## Requirements
- R1: After reset `push_valid` is 0, `mcmd_ready` is 1 and the list is empty, so a command taken right after reset produces no push.
- R2: A store is recorded only when `st_valid` and `st_gen` are both 1. The recorded value is the block number `st_addr / BLK_BYTES`, which is `st_addr[39:6]` with the defaults.
- R3: A flagged store whose block number equals a recorded entry that has not yet been accepted is not recorded again. An entry accepted by a push handshake in the same cycle counts as already sent, so the store is appended.
- R4: At most DEPTH (16) entries are recorded between two clears. A flagged store that arrives when DEPTH slots are used is dropped. Slots freed by sent entries are not reused until the list clears.
- R5: `mcmd_ready` is 1 exactly when no drain is in progress. A command is taken only on `mcmd_valid && mcmd_ready`, so a command offered during a drain waits until that drain ends.
- R6: During a drain, `push_blk` presents entries in insertion order. It advances by one entry per cycle with `push_valid && push_ready`, and it holds steady while `push_ready` is 0.
- R7: `push_dest` equals the destination of the command that started the drain and stays constant until the drain ends.
- R8: In the cycle that the last pending entry is accepted, the list clears. In the next cycle `push_valid` is 0 and `mcmd_ready` is 1.
- R9: A command taken while the list is empty, with no flagged store recorded in the same cycle, is consumed and produces no push.
- R10: Flagged stores recorded during a drain are appended and pushed by the same drain, after the entries recorded before them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store commit valid |
| st_gen | input | 1 | Store is marked as a generator |
| st_addr | input | ADDR_W (40) | Store byte address |
| mcmd_valid | input | 1 | Marshal command valid |
| mcmd_dest | input | CORE_W (3) | Destination core number |
| mcmd_ready | output | 1 | Marshal command accepted this cycle when valid |
| push_valid | output | 1 | Push request valid |
| push_ready | input | 1 | Push request accepted |
| push_blk | output | BLK_W (34) | Block number to push |
| push_dest | output | CORE_W (3) | Core to receive the block |

## Verification
The bench targets the cases where bookkeeping goes wrong. These are: several byte offsets inside one block, which a byte-grained compare would list several times; a seventeenth distinct block, which a missing capacity check would write over the head; a command offered during a drain, which a design without back-pressure would use to change the destination in mid-drain; a command on an empty list, which could start a drain with garbage in it; and a flagged store in the same cycle as the last handshake, which an early clear would lose. Random traffic with stalls on the push side also checks that a stalled request holds its block and destination steady.

// File: rtl/mb_pkg.sv
package mb_pkg;
  typedef enum logic {
    MB_COLLECT = 1'b0,
    MB_SEND    = 1'b1
  } mb_phase_e;

  function automatic int unsigned mb_cnt_width(input int unsigned depth);
    return $clog2(depth + 1);
  endfunction
endpackage

// File: rtl/mb_slot_array.sv
module mb_slot_array #(
  parameter int DEPTH = 16,
  parameter int BLK_W = 34,
  localparam int CNT_W = mb_pkg::mb_cnt_width(DEPTH),
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ins_req,
  input  logic [BLK_W-1:0] ins_blk,
  input  logic             pop,
  input  logic             clear,
  output logic [BLK_W-1:0] head_blk,
  output logic             ins_fire,
  output logic             drained_next,
  output logic             fill_next_nz,
  output logic [CNT_W-1:0] used_cnt
);
  logic [BLK_W-1:0] slot_q [DEPTH];
  logic [CNT_W-1:0] used_q, rd_q, rd_eff, used_nxt;
  logic [DEPTH-1:0] match_vec;
  logic             has_room, any_match;

  assign rd_eff = rd_q + CNT_W'(pop);

  // compare only against entries still waiting to be accepted
  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
      assign match_vec[g] = (CNT_W'(g) >= rd_eff) && (CNT_W'(g) < used_q) &&
                            (slot_q[g] == ins_blk);
    end
  endgenerate

  assign any_match    = |match_vec;
  assign has_room     = used_q < CNT_W'(DEPTH);
  assign ins_fire     = ins_req && !any_match && has_room;
  assign used_nxt     = used_q + CNT_W'(ins_fire);
  assign drained_next = (rd_eff == used_nxt);
  assign fill_next_nz = (used_nxt != '0);
  assign head_blk     = slot_q[rd_q[IDX_W-1:0]];
  assign used_cnt     = used_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      used_q <= '0;
      rd_q   <= '0;
    end else begin
      used_q <= used_nxt;
      rd_q   <= rd_eff;
    end
  end

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk) begin
        if (ins_fire && (used_q == CNT_W'(g))) slot_q[g] <= ins_blk;
      end
    end
  endgenerate

  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    used_q <= CNT_W'(DEPTH));

  a_r4_full_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (!has_room && !clear) |=> used_q == CNT_W'(DEPTH));

  a_r6_pop_advances: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !clear) |=> rd_q == $past(rd_q) + CNT_W'(1));
endmodule

// File: rtl/mb_drain_fsm.sv
module mb_drain_fsm #(
  parameter int CORE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [CORE_W-1:0] cmd_dest,
  output logic              cmd_ready,
  input  logic              fill_next_nz,
  input  logic              drained_next,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [CORE_W-1:0] out_dest,
  output logic              pop,
  output logic              done
);
  import mb_pkg::*;

  mb_phase_e         phase_q;
  logic [CORE_W-1:0] dest_q;
  logic              cmd_fire;

  assign cmd_ready = (phase_q == MB_COLLECT);
  assign cmd_fire  = cmd_valid && cmd_ready;
  assign out_valid = (phase_q == MB_SEND);
  assign pop       = out_valid && out_ready;
  assign done      = pop && drained_next;
  assign out_dest  = dest_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= MB_COLLECT;
      dest_q  <= '0;
    end else begin
      unique case (phase_q)
        MB_COLLECT: if (cmd_fire && fill_next_nz) begin
          phase_q <= MB_SEND;
          dest_q  <= cmd_dest;
        end
        MB_SEND: if (done) phase_q <= MB_COLLECT;
        default: phase_q <= MB_COLLECT;
      endcase
    end
  end

  a_r6_hold_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid);

  a_r7_dest_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !done) |=> (out_valid && $stable(out_dest)));

  a_r5_start_needs_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(cmd_valid));

  a_r8_exit: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!out_valid && cmd_ready));
endmodule

// File: rtl/mb_marshal_buf.sv
module mb_marshal_buf #(
  parameter int ADDR_W    = 40,
  parameter int BLK_BYTES = 64,
  parameter int DEPTH     = 16,
  parameter int CORES     = 8,
  localparam int OFF_W  = $clog2(BLK_BYTES),
  localparam int BLK_W  = ADDR_W - OFF_W,
  localparam int CORE_W = (CORES > 1) ? $clog2(CORES) : 1,
  localparam int CNT_W  = mb_pkg::mb_cnt_width(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_valid,
  input  logic              st_gen,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic              mcmd_valid,
  input  logic [CORE_W-1:0] mcmd_dest,
  output logic              mcmd_ready,
  output logic              push_valid,
  input  logic              push_ready,
  output logic [BLK_W-1:0]  push_blk,
  output logic [CORE_W-1:0] push_dest
);
  function automatic logic [BLK_W-1:0] blk_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:OFF_W];
  endfunction

  logic             rec_req, ins_fire, drained_next, fill_next_nz, pop, done;
  logic [CNT_W-1:0] used_cnt;

  assign rec_req = st_valid && st_gen;

  mb_slot_array #(.DEPTH(DEPTH), .BLK_W(BLK_W)) u_slots (
    .clk          (clk),
    .rst_n        (rst_n),
    .ins_req      (rec_req),
    .ins_blk      (blk_of(st_addr)),
    .pop          (pop),
    .clear        (done),
    .head_blk     (push_blk),
    .ins_fire     (ins_fire),
    .drained_next (drained_next),
    .fill_next_nz (fill_next_nz),
    .used_cnt     (used_cnt)
  );

  mb_drain_fsm #(.CORE_W(CORE_W)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid    (mcmd_valid),
    .cmd_dest     (mcmd_dest),
    .cmd_ready    (mcmd_ready),
    .fill_next_nz (fill_next_nz),
    .drained_next (drained_next),
    .out_ready    (push_ready),
    .out_valid    (push_valid),
    .out_dest     (push_dest),
    .pop          (pop),
    .done         (done)
  );

  a_r6_blk_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && !push_ready) |=> $stable(push_blk));

  a_r9_empty_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (mcmd_valid && mcmd_ready && used_cnt == '0 && !ins_fire) |=> !push_valid);

  a_r2_plain_store: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && !st_gen) |-> !ins_fire);
endmodule

// File: tb/mb_marshal_buf_test.sv
module mb_marshal_buf_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        st_valid = 0, st_gen = 0;
  logic [39:0] st_addr = '0;
  logic        mcmd_valid = 0;
  logic [2:0]  mcmd_dest = '0;
  logic        mcmd_ready, push_valid;
  logic        push_ready = 0;
  logic [33:0] push_blk;
  logic [2:0]  push_dest;

  always #5 clk = ~clk;

  mb_marshal_buf uut (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_gen(st_gen), .st_addr(st_addr),
    .mcmd_valid(mcmd_valid), .mcmd_dest(mcmd_dest), .mcmd_ready(mcmd_ready),
    .push_valid(push_valid), .push_ready(push_ready), .push_blk(push_blk),
    .push_dest(push_dest));

  int compared = 0, mismatched = 0, pushes_seen = 0;
  logic [33:0] mmem [16];
  int mused = 0, mrd = 0;
  bit mdrain = 0;
  logic [2:0] mdest = '0;

  function automatic logic [33:0] to_blk(input logic [39:0] a);
    return 34'(a / 40'd64);
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input bit sv, input bit sg, input logic [39:0] a, input bit mv,
                     input logic [2:0] md, input bit pr, input string tag);
    bit pop, hit, ins;
    int reff;
    logic [33:0] b;
    @(negedge clk);
    chk(push_valid == mdrain, {tag, " push_valid R8"}, push_valid, mdrain);
    chk(mcmd_ready == !mdrain, {tag, " mcmd_ready R5"}, mcmd_ready, !mdrain);
    if (mdrain) begin
      chk(push_blk == mmem[mrd], {tag, " push_blk R6"}, push_blk, mmem[mrd]);
      chk(push_dest == mdest, {tag, " push_dest R7"}, push_dest, mdest);
    end
    st_valid = sv; st_gen = sg; st_addr = a;
    mcmd_valid = mv; mcmd_dest = md; push_ready = pr;
    pop = mdrain && pr;
    if (push_valid && pr) pushes_seen++;
    reff = mrd + int'(pop);
    b = to_blk(a);
    hit = 0;
    for (int i = reff; i < mused; i++) if (mmem[i] == b) hit = 1;
    ins = sv && sg && !hit && (mused < 16);
    if (ins) begin mmem[mused] = b; mused++; end
    mrd = reff;
    if (pop && mrd == mused) begin
      mused = 0; mrd = 0; mdrain = 0;
    end else if (!mdrain && mv && mused > 0) begin
      mdrain = 1; mdest = md;
    end
  endtask

  task automatic drain_all(input string tag);
    for (int k = 0; k < 60 && mdrain; k++) cyc(0, 0, '0, 0, 3'd0, 1, tag);
    cyc(0, 0, '0, 0, 3'd0, 1, tag);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h0005eed1));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    // R1: idle outputs after reset, marshal on empty list gives nothing
    chk(push_valid == 0, "R1 push_valid", push_valid, 0);
    chk(mcmd_ready == 1, "R1 mcmd_ready", mcmd_ready, 1);
    pushes_seen = 0;
    cyc(0, 0, '0, 1, 3'd2, 1, "R1");
    repeat (3) cyc(0, 0, '0, 0, 3'd0, 1, "R1");
    chk(pushes_seen == 0, "R1 push count", pushes_seen, 0);

    // R2: only flagged stores are recorded
    pushes_seen = 0;
    cyc(1, 1, 40'h0000001040, 0, 0, 0, "R2");
    cyc(1, 0, 40'h0000002000, 0, 0, 0, "R2");
    cyc(0, 1, 40'h0000003000, 0, 0, 0, "R2");
    cyc(1, 1, 40'h0000004000, 0, 0, 0, "R2");
    cyc(1, 0, 40'h0000005000, 0, 0, 0, "R2");
    cyc(1, 1, 40'h0000006000, 1, 3'd5, 0, "R2");
    drain_all("R2");
    chk(pushes_seen == 3, "R2 push count", pushes_seen, 3);

    // R3: same block at several offsets
    pushes_seen = 0;
    cyc(1, 1, 40'h0000abc000, 0, 0, 0, "R3");
    cyc(1, 1, 40'h0000abc008, 0, 0, 0, "R3");
    cyc(1, 1, 40'h0000abc03f, 0, 0, 0, "R3");
    cyc(1, 1, 40'h0000abc040, 0, 0, 0, "R3");
    cyc(1, 1, 40'h0000abc010, 1, 3'd1, 0, "R3");
    drain_all("R3");
    chk(pushes_seen == 2, "R3 push count", pushes_seen, 2);

    // R4: 20 distinct blocks, only 16 kept
    pushes_seen = 0;
    for (int i = 0; i < 20; i++) cyc(1, 1, 40'(i * 64 + 40'h100000), 0, 0, 0, "R4");
    cyc(0, 0, '0, 1, 3'd7, 0, "R4");
    drain_all("R4");
    chk(pushes_seen == 16, "R4 push count", pushes_seen, 16);

    // R5/R7: command offered mid-drain with other dest, with stalls
    pushes_seen = 0;
    for (int i = 0; i < 4; i++) cyc(1, 1, 40'(i * 64 + 40'h200000), 0, 0, 0, "R5");
    cyc(0, 0, '0, 1, 3'd3, 0, "R5");
    for (int i = 0; i < 6; i++) cyc(0, 0, '0, 1, 3'd6, i[0], "R7");
    drain_all("R5");
    chk(pushes_seen == 4, "R5 push count", pushes_seen, 4);

    // R10: flagged store in the last-handshake cycle and mid-drain
    pushes_seen = 0;
    cyc(1, 1, 40'h0000300000, 0, 0, 0, "R10");
    cyc(1, 1, 40'h0000300040, 1, 3'd4, 0, "R10");
    cyc(1, 1, 40'h0000300080, 0, 0, 1, "R10");
    cyc(1, 1, 40'h00003000c0, 0, 0, 1, "R10");
    cyc(1, 1, 40'h0000300000, 0, 0, 1, "R10");
    drain_all("R10");
    chk(pushes_seen == 5, "R10 push count", pushes_seen, 5);

    // R9: empty list command
    pushes_seen = 0;
    cyc(0, 0, '0, 1, 3'd2, 1, "R9");
    repeat (3) cyc(0, 0, '0, 0, 0, 1, "R9");
    chk(pushes_seen == 0, "R9 push count", pushes_seen, 0);

    // random mix, R6 stalls
    for (int n = 0; n < 4000; n++) begin
      logic [39:0] a;
      a = {6'd0, 28'($urandom % 24), 6'($urandom)};
      cyc(($urandom % 2) == 0, ($urandom % 5) < 3, a, ($urandom % 20) == 0,
          3'($urandom), ($urandom % 10) < 7, "R6 random");
    end
    drain_all("R6");
    summary();
    $finish;
  end
endmodule